// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block is a small data cache for a processor that loads and stores single bytes. It holds 256 bytes in 64 lines of 4 bytes. Each line has a tag, a valid flag and a dirty flag. A byte address is split into three fields, lowest first: a 2-bit offset, a 6-bit line index and a tag made of the bits above them. Each address has exactly one line it can live in, so two addresses 256 bytes apart compete for the same line.

Stores that hit only change the cached line and mark it dirty. Stores that miss first bring in the whole block and then merge the byte, the same as loads. When a miss lands on a dirty line, the old block is written out before the new block is requested. The memory side moves one whole block per transfer and uses a request/acknowledge handshake. Two counters record hits and misses so that a test can measure hit rates.

The processor holds `cpu_req` with stable inputs until it sees `cpu_ready` high at a clock edge.

Top module: `dm_wb_cache`

## Requirements
- R1: The address is decoded as offset = bits [1:0], index = bits [7:2] and tag = bits [ADDR_W-1:8]. Two addresses whose difference is a multiple of 256 select the same line, and each evicts the other.
- R2: A request hits only when the indexed line is valid and its stored tag equals the address tag. On a hit, `cpu_ready` is high in the same cycle, and for a load `cpu_rdata` holds the addressed byte of the line in that cycle.
- R3: A store that hits changes only the cached byte and sets the line's dirty flag. It starts no memory transfer.
- R4: A load or store that misses fetches the block at the request's block-aligned address (`mem_we` = 0). It then completes in the cache; a store merges its byte into the fetched block. A miss on a clean line starts no memory write.
- R5: A miss on a valid dirty line first writes the old block to memory (`mem_we` = 1, address = old tag and index with offset zero). Only after that write is acknowledged does it request the new block.
- R6: `cpu_ready` is low from the cycle a miss is detected until the refill has been acknowledged. A hit takes a single cycle.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R8: `hit_count` rises by one for each request that hits on first presentation. `miss_count` rises by one for each request that misses. The completion cycle that follows a refill is not counted as a hit.
- R9: Reset clears every valid and dirty flag and zeroes both counters. After reset, the first access to any address misses and writes nothing back.
- R10: After reset, byte stores to addresses 0..511 in ascending order give 128 misses and 384 hits, a 75% hit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = byte store, 0 = byte load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Request completes at this edge |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | ADDR_W | Block-aligned byte address |
| mem_wdata | output | BLOCK_BYTES*8 | Block being written back |
| mem_rdata | input | BLOCK_BYTES*8 | Refill block, sampled with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |

## Verification
The hardest case to reach from the ports is a miss on a dirty line. It needs a store to one address, then an access to a different address with the same index, before any clean refill of that line. Ascending strides alone produce it only at regular points.

The random phase therefore draws addresses from four tags over sixteen lines, mixing loads and stores, so that dirty evictions happen often. The memory model inserts random acknowledge delays during both write-backs and refills. A final sweep over an unused region evicts every line, and the backing memory is then compared byte by byte with the reference.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } cache_st_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int LINES = 64,
   parameter int IDX_W = 6,
   parameter int TAG_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set,
   output logic [TAG_W-1:0] tag_o,
   output logic             valid_o,
   output logic             dirty_o
);
   logic [TAG_W-1:0] tags [LINES];
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;

   // Tag storage needs no reset: the valid flags guard it.
   always_ff @(posedge clk) begin
      if (fill_en) tags[idx] <= fill_tag;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (dirty_set) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   assign tag_o   = tags[idx];
   assign valid_o = valid_q[idx];
   assign dirty_o = dirty_q[idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int LINES = 64,
   parameter int IDX_W = 6,
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic               clk,
   input  logic [IDX_W-1:0]   idx,
   input  logic               fill_en,
   input  logic [LANES*8-1:0] fill_word,
   input  logic               byte_we,
   input  logic [OFF_W-1:0]   byte_sel,
   input  logic [7:0]         byte_wdata,
   output logic [LANES*8-1:0] word_o
);
   // One byte-wide array per lane, so a store writes one lane and a refill writes all of them.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_mem [LINES];
      always_ff @(posedge clk) begin
         if (fill_en)
            lane_mem[idx] <= fill_word[l*8 +: 8];
         else if (byte_we && byte_sel == OFF_W'(l))
            lane_mem[idx] <= byte_wdata;
      end
      assign word_o[l*8 +: 8] = lane_mem[idx];
   end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic             hit,
   input  logic             line_dirty,
   input  logic             mem_ack,
   output cache_st_e        state,
   output logic             cpu_ready,
   output logic             fill_en,
   output logic             byte_we,
   output logic             mem_req,
   output logic             mem_we,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);
   cache_st_e state_q, state_d;
   logic      replay_q;
   logic      accept, miss_det;

   assign accept    = (state_q == ST_IDLE) && cpu_req && hit;
   assign miss_det  = (state_q == ST_IDLE) && cpu_req && !hit;
   assign cpu_ready = (state_q == ST_IDLE) && (!cpu_req || hit);
   assign byte_we   = accept && cpu_we;
   assign fill_en   = (state_q == ST_FILL) && mem_ack;
   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_WBACK);
   assign state     = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (miss_det) state_d = line_dirty ? ST_WBACK : ST_FILL;
         ST_WBACK: if (mem_ack)  state_d = ST_FILL;
         ST_FILL:  if (mem_ack)  state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_IDLE;
         replay_q   <= 1'b0;
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         state_q <= state_d;
         if (fill_en)     replay_q <= 1'b1;
         else if (accept) replay_q <= 1'b0;
         if (accept && !replay_q) hit_count  <= hit_count + CNT_W'(1);
         if (miss_det)            miss_count <= miss_count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
   import cache_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int CACHE_BYTES = 256,
   parameter int BLOCK_BYTES = 4,
   parameter int CNT_W       = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cpu_req,
   input  logic                     cpu_we,
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic [7:0]               cpu_wdata,
   output logic [7:0]               cpu_rdata,
   output logic                     cpu_ready,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [BLOCK_BYTES*8-1:0] mem_wdata,
   input  logic [BLOCK_BYTES*8-1:0] mem_rdata,
   input  logic                     mem_ack,
   output logic [CNT_W-1:0]         hit_count,
   output logic [CNT_W-1:0]         miss_count
);
   localparam int OFF_W  = $clog2(BLOCK_BYTES);
   localparam int LINES  = CACHE_BYTES / BLOCK_BYTES;
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int WORD_W = BLOCK_BYTES * 8;

   if (BLOCK_BYTES < 2 || (1 << OFF_W) != BLOCK_BYTES) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two, at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("CACHE_BYTES/BLOCK_BYTES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the cache geometry");
   end

   logic [OFF_W-1:0]  a_off;
   logic [IDX_W-1:0]  a_idx;
   logic [TAG_W-1:0]  a_tag;
   logic [TAG_W-1:0]  line_tag;
   logic              line_valid, line_dirty, hit;
   logic              fill_en, byte_we;
   logic [WORD_W-1:0] line_word;
   cache_st_e         state;

   assign {a_tag, a_idx, a_off} = cpu_addr;
   assign hit = line_valid && (line_tag == a_tag);

   cache_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst(rst), .idx(a_idx), .fill_en(fill_en), .fill_tag(a_tag),
      .dirty_set(byte_we), .tag_o(line_tag), .valid_o(line_valid), .dirty_o(line_dirty)
   );

   cache_data_store #(.LINES(LINES), .IDX_W(IDX_W), .LANES(BLOCK_BYTES), .OFF_W(OFF_W)) u_data (
      .clk(clk), .idx(a_idx), .fill_en(fill_en), .fill_word(mem_rdata),
      .byte_we(byte_we), .byte_sel(a_off), .byte_wdata(cpu_wdata), .word_o(line_word)
   );

   cache_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .hit(hit),
      .line_dirty(line_valid && line_dirty), .mem_ack(mem_ack), .state(state),
      .cpu_ready(cpu_ready), .fill_en(fill_en), .byte_we(byte_we),
      .mem_req(mem_req), .mem_we(mem_we), .hit_count(hit_count), .miss_count(miss_count)
   );

   // A write-back goes to the victim's own address; a refill goes to the requested block.
   assign mem_addr  = {(state == ST_WBACK) ? line_tag : a_tag, a_idx, {OFF_W{1'b0}}};
   assign mem_wdata = line_word;

   always_comb begin
      cpu_rdata = '0;
      for (int l = 0; l < BLOCK_BYTES; l++)
         if (a_off == OFF_W'(l)) cpu_rdata = line_word[l*8 +: 8];
   end
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
   parameter int ADDR_W = 11,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);
   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

   // R5
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

   // R6
   busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !cpu_ready);

   // R6
   miss_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_req && !cpu_ready && !mem_req |=> mem_req);

   // R3
   hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_req && cpu_ready |=> !mem_req);

   // R8
   count_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(hit_count != $past(hit_count) && miss_count != $past(miss_count)));

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (CNT_W'(hit_count - $past(hit_count)) <= CNT_W'(1)) &&
      (CNT_W'(miss_count - $past(miss_count)) <= CNT_W'(1)));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> hit_count == '0 && miss_count == '0 && !mem_req);
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(BLOCK_BYTES*8), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready), .mem_req(mem_req),
   .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
   localparam int AW = 11;
   localparam int MEMSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [7:0]    cpu_wdata = '0, cpu_rdata;
   logic          cpu_ready, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic          mem_ack = 1'b0;
   logic [15:0]   hit_count, miss_count;

   dm_wb_cache u_dm_wb_cache (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
   );

   always #2 clk = ~clk;

   int n_tests = 0, n_fail = 0;
   logic [7:0] bmem [MEMSZ];
   int wb_cnt = 0, fill_cnt = 0, op_txn = 0;
   logic [AW-1:0] last_wb = '0;
   bit first_we = 1'b0;

   // Reference model: backing memory plus the line state the requirements imply.
   logic [7:0] rm_back [MEMSZ];
   logic [7:0] rm_line [64][4];
   logic [2:0] rm_tag [64];
   bit         rm_val [64];
   bit         rm_dirty [64];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Memory responder: random 0..2 cycle delay, one-cycle acknowledge.
   initial begin
      int dly = 0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (mem_req) begin
            if (dly == 0) begin
               if (op_txn == 0) first_we = mem_we;
               op_txn++;
               if (mem_we) begin
                  for (int b = 0; b < 4; b++) bmem[int'(mem_addr) + b] = mem_wdata[b*8 +: 8];
                  wb_cnt++;
                  last_wb = mem_addr;
               end else begin
                  for (int b = 0; b < 4; b++) mem_rdata[b*8 +: 8] = bmem[int'(mem_addr) + b];
                  fill_cnt++;
               end
               mem_ack = 1'b1;
               dly = $urandom % 3;
            end else dly--;
         end
      end
   end

   task automatic model_access(input bit we, input logic [AW-1:0] a, input logic [7:0] d,
                               output bit e_hit, output bit e_wb, output logic [AW-1:0] e_wba,
                               output logic [7:0] e_rd);
      int idx = int'(a[7:2]);
      int off = int'(a[1:0]);
      e_hit = rm_val[idx] && rm_tag[idx] == a[10:8];
      e_wb = 1'b0;
      e_wba = '0;
      if (!e_hit) begin
         if (rm_val[idx] && rm_dirty[idx]) begin
            e_wb = 1'b1;
            e_wba = {rm_tag[idx], a[7:2], 2'b00};
            for (int b = 0; b < 4; b++) rm_back[int'(e_wba) + b] = rm_line[idx][b];
         end
         for (int b = 0; b < 4; b++) rm_line[idx][b] = rm_back[int'({a[10:2], 2'b00}) + b];
         rm_tag[idx] = a[10:8];
         rm_val[idx] = 1'b1;
         rm_dirty[idx] = 1'b0;
      end
      if (we) begin
         rm_line[idx][off] = d;
         rm_dirty[idx] = 1'b1;
      end
      e_rd = rm_line[idx][off];
   endtask

   task automatic op(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
      bit e_hit, e_wb;
      logic [AW-1:0] e_wba;
      logic [7:0] e_rd, rd;
      int waits = 0, wb0 = wb_cnt, fl0 = fill_cnt;
      model_access(we, a, d, e_hit, e_wb, e_wba, e_rd);
      @(negedge clk);
      op_txn = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      forever begin
         #1;
         if (cpu_ready) begin rd = cpu_rdata; break; end
         waits++;
         @(negedge clk);
      end
      @(posedge clk);
      #1 cpu_req = 1'b0;
      // R2 R6: a hit is ready at once, a miss stalls
      check((waits == 0) == e_hit, "R2/R6 hit latency", waits, e_hit ? 0 : 1);
      if (!we) check(rd == e_rd, "R2 load data", rd, e_rd);
      // R3 R5: write-back only on a dirty victim
      check((wb_cnt - wb0) == int'(e_wb), "R3/R5 write-back count", wb_cnt - wb0, e_wb);
      if (e_wb) begin
         check(last_wb == e_wba, "R5 victim address", last_wb, e_wba);
         check(first_we == 1'b1, "R5 write-back precedes fetch", first_we, 1);
      end
      // R4: exactly one refill per miss
      check((fill_cnt - fl0) == int'(!e_hit), "R4 refill count", fill_cnt - fl0, !e_hit);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 64; i++) begin rm_val[i] = 1'b0; rm_dirty[i] = 1'b0; end
      #1;
      // R9
      check(hit_count == 0 && miss_count == 0, "R9 counters cleared", hit_count + miss_count, 0);
      check(cpu_ready == 1'b1 && mem_req == 1'b0, "R9 idle after reset", {cpu_ready, mem_req}, 2);
   endtask

   task automatic phase_counts(input string req, input int h0, input int m0,
                               input int eh, input int em);
      #1;
      check(int'(hit_count) - h0 == eh, {req, " hits"}, int'(hit_count) - h0, eh);
      check(int'(miss_count) - m0 == em, {req, " misses"}, int'(miss_count) - m0, em);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int h0, m0, bad;
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < MEMSZ; i++) begin
         bmem[i] = 8'($urandom);
         rm_back[i] = bmem[i];
      end
      do_reset();

      // R10 R1: ascending byte stores over 512 fresh bytes
      h0 = hit_count; m0 = miss_count;
      for (int i = 0; i < 512; i++) op(1'b1, AW'(i), 8'h01);
      phase_counts("R10 stride-1", h0, m0, 384, 128);

      // R8: stride 2 over the same region; the first half was evicted
      h0 = hit_count; m0 = miss_count;
      for (int i = 0; i < 512; i += 2) op(1'b1, AW'(i), 8'h02);
      phase_counts("R8 stride-2", h0, m0, 128, 128);

      // R1: stride 32, addresses 256 apart evict each other, every access misses
      for (int p = 0; p < 2; p++) begin
         h0 = hit_count; m0 = miss_count;
         for (int i = 0; i < 512; i += 32) op(1'b1, AW'(i), 8'h03);
         phase_counts("R1 stride-32", h0, m0, 0, 16);
      end

      // R9: reset drops dirty lines, no write-back on the next miss
      do_reset();
      op(1'b0, AW'(0), 8'h00);
      phase_counts("R9 post-reset", 0, 0, 0, 1);

      // Random mix across four tags and sixteen lines
      for (int n = 0; n < 600; n++) begin
         logic [AW-1:0] a = AW'((($urandom % 4) << 8) | ($urandom % 64));
         op(1'($urandom % 2), a, 8'($urandom));
      end

      // Flush by reading an untouched region, then compare backing memory
      for (int i = 0; i < 64; i++) op(1'b0, AW'(1536 + i * 4), 8'h00);
      for (int blk = 0; blk < 256; blk++) begin
         bad = 0;
         for (int b = 0; b < 4; b++) if (bmem[blk*4+b] !== rm_back[blk*4+b]) bad++;
         // R3 R4 R5: memory holds exactly the written-back data
         check(bad == 0, "R5 memory contents", bad, 0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule